// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one data-movement channel driven by a chain of transfer records kept in local memory. Software points the channel at the first record and sets the enable bit. The channel reads the record over a word-wide read port, moves the requested number of words from a source area to a destination area over a word-wide read/write port, and then follows the record's link to the next record. The walk stops at a record whose link is zero.

Each record occupies an 8-word slot that starts on an 8-word boundary. The channel uses four of its words: word 0 holds the link to the next record, word 1 the source word address, word 2 the destination word address, and word 3 the number of words to move (low counter bits). Words 4 to 7 are never read. Clearing the enable bit pauses the copy between words without losing its place. A restart option re-reads the record that was loaded last, so software can patch that record and run it again.

Software sees four registers: control, status, the address of the next record to load, and the address of the record loaded most recently. Errors from either memory port, or a misaligned record address, stop the channel and stay latched until software clears them.

Top module: `chain_dma`

## Requirements
- R1: After reset all four registers read 0 and neither memory port makes a request.
- R2: Register offsets are 0 control (bit 0 enable, bit 1 restart), 1 status (bit 0 busy, read-only; bit 1 alignment error; bit 2 bus error; writing 1 to an error bit clears it), 2 next-record address (read/write), 3 loaded-record address (read-only). A write is visible on the read port from the clock edge that samples the strobe.
- R3: A write of enable=1 with restart=0 while idle and free of errors makes the channel fetch words 0 to 3 of the record at the next-record address. Once loaded, the loaded-record register holds that address and the next-record register holds the record's link.
- R4: For a record with count N > 0, the channel moves exactly N words: each one is read from source+i and then written to destination+i, for i from 0 to N-1.
- R5: After the last word of a record, a nonzero link makes the channel fetch the record at that link. A zero link makes it fetch nothing more and clear the busy bit.
- R6: A record with count 0 moves no data. The channel goes straight on to its link, or to completion.
- R7: A record address (the start address or a link) whose low 3 bits are not all zero sets the alignment error bit and clears busy. No word of that record is fetched.
- R8: An error response on either port sets the bus error bit, clears busy and stops the channel.
- R9: A write of enable=1 has no start effect while the channel is busy or while any error bit is set.
- R10: Clearing enable while busy pauses the copy after the word in progress. Busy stays 1 and no further memory writes occur. Setting enable again continues with the next word, and the final data is complete.
- R11: A write of enable=1 with restart=1 while idle re-fetches the record at the loaded-record address, ignoring the next-record register.
- R12: Both ports use a request/response handshake. A request holds its address (and, on the data port, its direction) until the valid or acknowledge pulse, which may come after any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| dsc_req | output | 1 | Record read request |
| dsc_addr | output | AW | Record word address |
| dsc_valid | input | 1 | Record read response pulse |
| dsc_err | input | 1 | Record read error, qualified by dsc_valid |
| dsc_data | input | DW | Record read data |
| mem_req | output | 1 | Data port request |
| mem_we | output | 1 | Data port direction, 1 = write |
| mem_addr | output | AW | Data port word address |
| mem_wdata | output | DW | Data port write data |
| mem_ack | input | 1 | Data port response pulse |
| mem_err | input | 1 | Data port error, qualified by mem_ack |
| mem_rdata | input | DW | Data port read data |

## Verification
The bench sweeps every pairing of record-port and data-port latency from zero to three wait cycles over a three-record chain. The middle record of that chain has count zero. A channel that ignored the count would overwrite the zero-count record's destination, and one that sampled data before the response would copy stale words. Misaligned start addresses and misaligned links are both injected, as are errors on the record port and the data port; a faulty design would fetch a bad record or keep running after an error. Pause, restart-from-loaded-record and a start attempted while busy are each exercised. These catch a design that aborts or skips words on pause, reloads the wrong record, or starts a second chain on top of the first.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    // record slot geometry
    localparam int unsigned SLOT_WORDS  = 8;
    localparam int unsigned ALIGN_W     = $clog2(SLOT_WORDS);
    localparam int unsigned FETCH_WORDS = 4;
    localparam int unsigned IDX_W       = $clog2(FETCH_WORDS);

    // word positions inside a record
    localparam int W_LINK = 0;
    localparam int W_SRC  = 1;
    localparam int W_DST  = 2;
    localparam int W_CNT  = 3;

    // register offsets
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_NEXT = 2'd2;
    localparam logic [1:0] RA_CUR  = 2'd3;

    // control and status bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_RST   = 1;
    localparam int ST_BUSY   = 0;
    localparam int ST_ALIGN  = 1;
    localparam int ST_BUSERR = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_DESC,
        S_SETUP,
        S_READ_DATA,
        S_WRITE_DATA,
        S_SUSPENDED,
        S_DONE
    } dma_state_e;

    function automatic logic slot_aligned(input logic [ALIGN_W-1:0] low_bits);
        return low_bits == '0;
    endfunction

endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          active,
    input  logic          set_align,
    input  logic          set_bus,
    input  logic          load_en,
    input  logic [AW-1:0] load_cur,
    input  logic [AW-1:0] load_next,
    output logic          ctl_enable,
    output logic          start,
    output logic          start_resume,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] cur_addr,
    output logic          err_align,
    output logic          err_bus
);

    logic ctl_restart;
    logic ctrl_hit, stat_hit, next_hit;
    logic unused_wdata;

    assign ctrl_hit     = reg_wr && (reg_addr == RA_CTRL);
    assign stat_hit     = reg_wr && (reg_addr == RA_STAT);
    assign next_hit     = reg_wr && (reg_addr == RA_NEXT);
    assign unused_wdata = ^reg_wdata[DW-1:AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_enable   <= 1'b0;
            ctl_restart  <= 1'b0;
            start        <= 1'b0;
            start_resume <= 1'b0;
            next_addr    <= '0;
            cur_addr     <= '0;
            err_align    <= 1'b0;
            err_bus      <= 1'b0;
        end else begin
            start <= 1'b0;
            if (ctrl_hit) begin
                ctl_enable  <= reg_wdata[CTL_EN];
                ctl_restart <= reg_wdata[CTL_RST];
                if (reg_wdata[CTL_EN] && !active && !err_align && !err_bus && !start) begin
                    start        <= 1'b1;
                    start_resume <= reg_wdata[CTL_RST];
                end
            end
            err_align <= set_align | (err_align & ~(stat_hit & reg_wdata[ST_ALIGN]));
            err_bus   <= set_bus   | (err_bus   & ~(stat_hit & reg_wdata[ST_BUSERR]));
            if (load_en) begin
                cur_addr  <= load_cur;
                next_addr <= load_next;
            end else if (next_hit) begin
                next_addr <= reg_wdata[AW-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTL_EN]  = ctl_enable;
                reg_rdata[CTL_RST] = ctl_restart;
            end
            RA_STAT: begin
                reg_rdata[ST_BUSY]   = active;
                reg_rdata[ST_ALIGN]  = err_align;
                reg_rdata[ST_BUSERR] = err_bus;
            end
            RA_NEXT: reg_rdata = DW'(next_addr);
            default: reg_rdata = DW'(cur_addr);
        endcase
    end

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_resume,
    input  logic          enable,
    input  logic [AW-1:0] next_addr,
    input  logic [AW-1:0] cur_addr,
    output logic          dsc_req,
    output logic [AW-1:0] dsc_addr,
    input  logic          dsc_valid,
    input  logic          dsc_err,
    input  logic [DW-1:0] dsc_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          active,
    output logic          set_align,
    output logic          set_bus,
    output logic          load_en,
    output logic [AW-1:0] load_cur,
    output logic [AW-1:0] load_next
);

    localparam int USED_W = (AW > CNT_W) ? AW : CNT_W;

    typedef struct packed {
        logic [AW-1:0]    link;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
    } desc_t;

    dma_state_e       state;
    desc_t            desc;
    logic [AW-1:0]    base;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    data_q;

    logic [AW-1:0] start_addr;
    logic          last_beat, chain_go, link_zero, link_ok;
    dma_state_e    chain_state, data_state;
    logic          unused_dsc;

    assign unused_dsc = ^dsc_data[DW-1:USED_W];

    always_comb begin
        start_addr  = start_resume ? cur_addr : next_addr;
        last_beat   = (state == S_WRITE_DATA) && mem_ack && !mem_err && (desc.cnt == CNT_W'(1));
        chain_go    = ((state == S_SETUP) && (desc.cnt == '0)) || last_beat;
        link_zero   = (desc.link == '0);
        link_ok     = slot_aligned(desc.link[ALIGN_W-1:0]);
        chain_state = link_zero ? S_DONE : (link_ok ? S_FETCH_DESC : S_IDLE);
        data_state  = enable ? S_READ_DATA : S_SUSPENDED;
        set_align   = ((state == S_IDLE) && start && !slot_aligned(start_addr[ALIGN_W-1:0]))
                    || (chain_go && !link_zero && !link_ok);
        set_bus     = ((state == S_FETCH_DESC) && dsc_valid && dsc_err)
                    || (mem_req && mem_ack && mem_err);
    end

    assign active    = (state != S_IDLE) && (state != S_DONE);
    assign dsc_req   = (state == S_FETCH_DESC);
    assign dsc_addr  = base | AW'(idx);
    assign mem_req   = (state == S_READ_DATA) || (state == S_WRITE_DATA);
    assign mem_we    = (state == S_WRITE_DATA);
    assign mem_addr  = mem_we ? desc.dst : desc.src;
    assign mem_wdata = data_q;
    assign load_en   = (state == S_SETUP);
    assign load_cur  = base;
    assign load_next = desc.link;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            desc   <= '0;
            base   <= '0;
            idx    <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start && slot_aligned(start_addr[ALIGN_W-1:0])) begin
                        state <= S_FETCH_DESC;
                        base  <= start_addr;
                        idx   <= '0;
                    end
                end
                S_FETCH_DESC: begin
                    if (dsc_valid) begin
                        if (dsc_err) begin
                            state <= S_IDLE;
                        end else begin
                            case (int'(idx))
                                W_LINK:  desc.link <= dsc_data[AW-1:0];
                                W_SRC:   desc.src  <= dsc_data[AW-1:0];
                                W_DST:   desc.dst  <= dsc_data[AW-1:0];
                                default: desc.cnt  <= dsc_data[CNT_W-1:0];
                            endcase
                            if (idx == IDX_W'(FETCH_WORDS - 1)) state <= S_SETUP;
                            else                                idx   <= idx + 1'b1;
                        end
                    end
                end
                S_SETUP: begin
                    if (desc.cnt == '0) begin
                        state <= chain_state;
                        base  <= desc.link;
                        idx   <= '0;
                    end else begin
                        state <= data_state;
                    end
                end
                S_READ_DATA: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state <= S_IDLE;
                        end else begin
                            data_q <= mem_rdata;
                            state  <= S_WRITE_DATA;
                        end
                    end
                end
                S_WRITE_DATA: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state <= S_IDLE;
                        end else begin
                            desc.cnt <= desc.cnt - 1'b1;
                            desc.src <= desc.src + 1'b1;
                            desc.dst <= desc.dst + 1'b1;
                            if (last_beat) begin
                                state <= chain_state;
                                base  <= desc.link;
                                idx   <= '0;
                            end else begin
                                state <= data_state;
                            end
                        end
                    end
                end
                S_SUSPENDED: begin
                    if (enable) state <= S_READ_DATA;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          dsc_req,
    output logic [AW-1:0] dsc_addr,
    input  logic          dsc_valid,
    input  logic          dsc_err,
    input  logic [DW-1:0] dsc_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata
);

    logic          active, set_align, set_bus, load_en;
    logic [AW-1:0] load_cur, load_next, next_addr, cur_addr;
    logic          ctl_enable, start, start_resume, err_align, err_bus;

    chain_dma_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .active(active), .set_align(set_align), .set_bus(set_bus),
        .load_en(load_en), .load_cur(load_cur), .load_next(load_next),
        .ctl_enable(ctl_enable), .start(start), .start_resume(start_resume),
        .next_addr(next_addr), .cur_addr(cur_addr),
        .err_align(err_align), .err_bus(err_bus)
    );

    chain_dma_engine #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst(rst),
        .start(start), .start_resume(start_resume), .enable(ctl_enable),
        .next_addr(next_addr), .cur_addr(cur_addr),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_valid(dsc_valid),
        .dsc_err(dsc_err), .dsc_data(dsc_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .active(active), .set_align(set_align), .set_bus(set_bus),
        .load_en(load_en), .load_cur(load_cur), .load_next(load_next)
    );

endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          dsc_req,
    input logic [AW-1:0] dsc_addr,
    input logic          dsc_valid,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          ctl_enable,
    input logic          err_align,
    input logic          err_bus,
    input logic          active
);

    // R12: a record request waits with a steady address for its response
    a_r12_dsc_hold: assert property (@(posedge clk) disable iff (rst)
        (dsc_req && !dsc_valid) |=> (dsc_req && $stable(dsc_addr)));

    // R12: a data request keeps address and direction until acknowledged
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: with an error latched no record fetch can begin
    a_r9_err_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
        (err_align || err_bus) |=> !dsc_req);

    // R10: a write completing while enable is low is followed by a pause
    a_r10_pause_after_word: assert property (@(posedge clk) disable iff (rst)
        (!ctl_enable && mem_req && mem_we && mem_ack) |=> !mem_req);

    // R8: a newly latched bus error leaves the channel not busy
    a_r8_bus_err_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(err_bus) |-> !active);

    // R7: a newly latched alignment error comes with no record fetch
    a_r7_align_no_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(err_align) |-> (!dsc_req && !active));

endmodule

bind chain_dma chain_dma_checker #(.AW(AW)) i_chk (
    .clk(clk), .rst(rst),
    .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_valid(dsc_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .ctl_enable(ctl_enable), .err_align(err_align), .err_bus(err_bus), .active(active)
);

// File: tb/test_chain_dma.sv
module test_chain_dma;

    localparam int DW = 32;
    localparam int AW = 16;
    localparam logic [31:0] SENT = 32'h5EE5_5EE5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dsc_req;
    logic [AW-1:0] dsc_addr;
    logic          dsc_valid = 1'b0;
    logic          dsc_err = 1'b0;
    logic [DW-1:0] dsc_data = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    logic [31:0] mem [0:255];
    int lat_d = 0, lat_m = 0, dcnt = 0, mcnt = 0;
    int n_dsc = 0, n_wr = 0;
    logic [AW-1:0] bad_dsc = 16'hFFFF, bad_mem = 16'hFFFF;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    chain_dma #(.DW(DW), .AW(AW)) i_chain_dma (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_valid(dsc_valid),
        .dsc_err(dsc_err), .dsc_data(dsc_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    // record port model with programmable wait cycles
    always @(posedge clk) begin
        if (rst) begin
            dsc_valid <= 1'b0; dcnt <= 0;
        end else if (dsc_valid) begin
            dsc_valid <= 1'b0; dcnt <= 0;
        end else if (dsc_req) begin
            if (dcnt >= lat_d) begin
                dsc_valid <= 1'b1;
                dsc_data  <= mem[dsc_addr[7:0]];
                dsc_err   <= (dsc_addr == bad_dsc);
                n_dsc     <= n_dsc + 1;
            end else dcnt <= dcnt + 1;
        end
    end

    // data port model with programmable wait cycles
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mcnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; mcnt <= 0;
        end else if (mem_req) begin
            if (mcnt >= lat_m) begin
                mem_ack   <= 1'b1;
                mem_err   <= (mem_addr == bad_mem);
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we && mem_addr != bad_mem) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    n_wr <= n_wr + 1;
                end
            end else mcnt <= mcnt + 1;
        end
    end

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 ^ (32'(a) * 32'h0001_0003);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int b, input int link, input int src, input int dst, input int cnt);
        mem[b] = 32'(link); mem[b+1] = 32'(src); mem[b+2] = 32'(dst); mem[b+3] = 32'(cnt);
        for (int k = 4; k < 8; k++) mem[b+k] = 32'hFFFF_FFFF;
    endtask

    task automatic clear_dst();
        for (int k = 8'hC0; k < 256; k++) mem[k] = SENT;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        bit done = 0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3000 && !done; k++) begin
            rd_reg(2'd1, s);
            if (!s[0]) done = 1;
        end
        if (!done) chk({tag, " busy never cleared"}, 32'd1, 32'd0);
    endtask

    task automatic check_copy(input string tag, input int src, input int dst, input int n);
        for (int k = 0; k < n; k++) chk(tag, mem[dst+k], pat(src+k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int d0, w0, wsnap;
        for (int k = 0; k < 256; k++) mem[k] = pat(k);
        clear_dst();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        for (int r = 0; r < 4; r++) begin
            rd_reg(2'(r), v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 no record request", 32'(dsc_req), 32'd0);
        chk("R1 no data request", 32'(mem_req), 32'd0);

        // R2: next register write/readback, busy bit read-only
        wr_reg(2'd2, 32'h0000_0040);
        rd_reg(2'd2, v); chk("R2 next readback", v, 32'h40);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v); chk("R2 busy bit read-only", v, 32'd0);

        // R3 R4 R5: single record
        put_desc(8'h40, 0, 8'h80, 8'hC0, 4);
        d0 = n_dsc; w0 = n_wr;
        wr_reg(2'd0, 32'h1);
        wait_idle("R3");
        check_copy("R4 single copy", 8'h80, 8'hC0, 4);
        chk("R4 word after count untouched", mem[8'hC4], SENT);
        chk("R4 write count", 32'(n_wr - w0), 32'd4);
        chk("R3 record words fetched", 32'(n_dsc - d0), 32'd4);
        rd_reg(2'd3, v); chk("R3 loaded-record address", v, 32'h40);
        rd_reg(2'd2, v); chk("R3 next takes link", v, 32'd0);
        rd_reg(2'd1, v); chk("R5 busy clear at end", v, 32'd0);

        // R5 R6 R12: three-record chain across latency sweep
        put_desc(8'h10, 8'h20, 8'h80, 8'hC0, 2);
        put_desc(8'h20, 8'h30, 8'h90, 8'hD0, 0);
        put_desc(8'h30, 0,     8'h84, 8'hC8, 3);
        for (int ld = 0; ld < 4; ld++) begin
            for (int lm = 0; lm < 4; lm++) begin
                lat_d = ld; lat_m = lm;
                clear_dst();
                wr_reg(2'd2, 32'h10);
                d0 = n_dsc; w0 = n_wr;
                wr_reg(2'd0, 32'h1);
                wait_idle("R12");
                check_copy("R12 chain rec0", 8'h80, 8'hC0, 2);
                check_copy("R5 chain rec2", 8'h84, 8'hC8, 3);
                chk("R6 zero count writes nothing", mem[8'hD0], SENT);
                chk("R6 total writes", 32'(n_wr - w0), 32'd5);
                chk("R5 records followed", 32'(n_dsc - d0), 32'd12);
                rd_reg(2'd3, v); chk("R5 last loaded record", v, 32'h30);
            end
        end
        lat_d = 1; lat_m = 1;

        // R7: misaligned start
        wr_reg(2'd2, 32'h23);
        d0 = n_dsc;
        wr_reg(2'd0, 32'h1);
        repeat (6) @(negedge clk);
        rd_reg(2'd1, v); chk("R7 misaligned start flags", v, 32'h2);
        chk("R7 no fetch of misaligned record", 32'(n_dsc - d0), 32'd0);

        // R9: start blocked while error latched
        wr_reg(2'd2, 32'h40);
        wr_reg(2'd0, 32'h1);
        repeat (8) @(negedge clk);
        chk("R9 no fetch with error set", 32'(n_dsc - d0), 32'd0);
        rd_reg(2'd1, v); chk("R9 status unchanged", v, 32'h2);
        wr_reg(2'd1, 32'h6);
        rd_reg(2'd1, v); chk("R2 write-one clears errors", v, 32'd0);

        // R7: misaligned link after a good record
        clear_dst();
        put_desc(8'h40, 8'h4C, 8'h80, 8'hC0, 2);
        wr_reg(2'd2, 32'h40);
        d0 = n_dsc; w0 = n_wr;
        wr_reg(2'd0, 32'h1);
        wait_idle("R7");
        rd_reg(2'd1, v); chk("R7 misaligned link flags", v, 32'h2);
        chk("R7 first record data moved", 32'(n_wr - w0), 32'd2);
        chk("R7 link record not fetched", 32'(n_dsc - d0), 32'd4);
        wr_reg(2'd1, 32'h6);

        // R8: error on record port
        put_desc(8'h40, 0, 8'h80, 8'hC0, 4);
        bad_dsc = 16'h41;
        wr_reg(2'd2, 32'h40);
        w0 = n_wr;
        wr_reg(2'd0, 32'h1);
        wait_idle("R8");
        rd_reg(2'd1, v); chk("R8 record port error", v, 32'h4);
        chk("R8 no data after record error", 32'(n_wr - w0), 32'd0);
        bad_dsc = 16'hFFFF;
        wr_reg(2'd1, 32'h6);

        // R8: error on data port read of the second word
        bad_mem = 16'h81;
        wr_reg(2'd2, 32'h40);
        w0 = n_wr;
        wr_reg(2'd0, 32'h1);
        wait_idle("R8");
        rd_reg(2'd1, v); chk("R8 data port error", v, 32'h4);
        chk("R8 stopped after one word", 32'(n_wr - w0), 32'd1);
        bad_mem = 16'hFFFF;
        wr_reg(2'd1, 32'h6);

        // R10: pause and continue
        clear_dst();
        lat_m = 2;
        put_desc(8'h40, 0, 8'h80, 8'hC0, 20);
        wr_reg(2'd2, 32'h40);
        w0 = n_wr;
        wr_reg(2'd0, 32'h1);
        repeat (25) @(negedge clk);
        wr_reg(2'd0, 32'h0);
        repeat (12) @(negedge clk);
        wsnap = n_wr;
        repeat (40) @(negedge clk);
        chk("R10 no writes while paused", 32'(n_wr), 32'(wsnap));
        rd_reg(2'd1, v); chk("R10 busy while paused", v, 32'h1);
        chk("R10 paused mid-record", 32'((wsnap - w0) > 0 && (wsnap - w0) < 20), 32'd1);
        wr_reg(2'd0, 32'h1);
        wait_idle("R10");
        chk("R10 total writes after continue", 32'(n_wr - w0), 32'd20);
        check_copy("R10 data after continue", 8'h80, 8'hC0, 20);
        lat_m = 1;

        // R9: start attempt while busy is ignored
        clear_dst();
        put_desc(8'h40, 0, 8'h80, 8'hC0, 6);
        put_desc(8'h60, 0, 8'h90, 8'hE0, 3);
        wr_reg(2'd2, 32'h40);
        d0 = n_dsc;
        wr_reg(2'd0, 32'h1);
        repeat (8) @(negedge clk);
        wr_reg(2'd2, 32'h60);
        wr_reg(2'd0, 32'h1);
        wait_idle("R9");
        check_copy("R9 first chain intact", 8'h80, 8'hC0, 6);
        chk("R9 second chain not run", mem[8'hE0], SENT);
        chk("R9 only one record fetched", 32'(n_dsc - d0), 32'd4);

        // R11: restart from loaded record after patching it
        clear_dst();
        put_desc(8'h40, 0, 8'hA0, 8'hF0, 3);
        d0 = n_dsc;
        wr_reg(2'd0, 32'h3);
        wait_idle("R11");
        check_copy("R11 patched record run", 8'hA0, 8'hF0, 3);
        chk("R11 next register ignored", mem[8'hE0], SENT);
        chk("R11 old destination untouched", mem[8'hC0], SENT);
        chk("R11 record refetched once", 32'(n_dsc - d0), 32'd4);
        rd_reg(2'd3, v); chk("R11 loaded address kept", v, 32'h40);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule